// File: doc/BRIEF.md
# Serial Radio Frame Transmitter

This block assembles one radio frame and sends it one bit at a time on a single-frequency simplex link. A frame is requested by a start pulse with the header fields and a payload byte count held on the inputs. The block then sends a clock-recovery preamble, a start delimiter, the payload length, the packed header, the payload bytes and a CRC. It advances by one bit on each pulse of a bit-rate tick that an external divider supplies.

Payload bytes come in on a ready/valid byte port at the moment each byte is due to start. A transmit-active output is high for the whole frame, so the receive path can be blanked while the shared frequency is in use. If a payload byte is missing when it is due, the frame is cut short and an underrun flag is raised.

Top module: `radio_frame_tx`

## Requirements
- R1: After reset txActive, txBit, byteReady and underrun are all 0.
- R2: startReq is accepted only while txActive is 0. On the clock after acceptance, txActive is 1 and txBit shows the first preamble bit (1). A startReq during a frame has no effect on the bits sent.
- R3: Exactly one bit is consumed on each clock that has bitTick high while txActive is 1. txBit holds between ticks. A complete frame lasts 100 + 8*len ticks, where len is the payload byte count.
- R4: The frame opens with 24 preamble bits that alternate and start with 1. The 16-bit delimiter follows, MSB first, with the default value 16'hF3A0.
- R5: The 6-bit payload length comes next, MSB first. The 38-bit header follows, MSB first, in this field order: TA(6), RA(6), SA(6), DA(6), type(3), ack(1), reserved(1), sequence(8), more(1).
- R6: Payload bytes are sent MSB first, in the order accepted. byteReady is high for one clock, on the tick that ends the bit before each byte. A byte is taken when byteReady and byteValid are both high. There are exactly len handshakes per frame.
- R7: The last 16 bits are a CRC sent MSB first. The CRC uses polynomial 0x1021 with initial value 0xFFFF and no final inversion. It is computed over the length, header and payload bits in send order.
- R8: If byteValid is 0 while byteReady is 1, txActive falls on that clock edge and txBit returns to 0. underrun then stays 1 until the next accepted start, which clears it.
- R9: txActive falls on the tick that consumes the last CRC bit. With len 0, the CRC follows the header directly and no byte is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-clock pulse per bit period |
| startReq | input | 1 | Request to send a frame |
| payLen | input | 6 | Payload byte count, sampled at start |
| taddr | input | 6 | Header TA field |
| raddr | input | 6 | Header RA field |
| saddr | input | 6 | Header SA field |
| daddr | input | 6 | Header DA field |
| frameKind | input | 3 | Header type field |
| ackReq | input | 1 | Header ack bit |
| rsvBit | input | 1 | Header reserved bit |
| seqNum | input | 8 | Header sequence number |
| moreFlag | input | 1 | Header more bit |
| byteData | input | 8 | Payload byte |
| byteValid | input | 1 | Payload byte present |
| byteReady | output | 1 | Payload byte taken this clock |
| txBit | output | 1 | Serial line bit |
| txActive | output | 1 | Frame in progress; blanks reception |
| underrun | output | 1 | Last frame aborted for lack of data |

## Verification
The hardest case to reach is a starved payload in the middle of a frame. The byte source has to withdraw its data on exactly the tick where a later byte falls due. By then the CRC has already folded in part of the payload and earlier handshakes have completed. The bench drives the byte source from its own frame loop and drops byteValid once a chosen number of bytes has been consumed. This lets it cut a frame at the first byte or at a later one, and check the tick count at which txActive falls. A start request held during a running frame is produced the same way. The full bit stream is then compared to confirm that the request changed nothing.

// File: rtl/radio_tx_pkg.sv
package radio_tx_pkg;
  typedef enum logic [1:0] {SEG_IDLE, SEG_HEAD, SEG_PAY, SEG_CRC} seg_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic byteLoad;
    logic crcUpd;
    logic crcShift;
  } strobe_t;

  // field order equals send order (first field is MSB)
  typedef struct packed {
    logic [5:0] ta;
    logic [5:0] ra;
    logic [5:0] sa;
    logic [5:0] da;
    logic [2:0] kind;
    logic       ack;
    logic       rsv;
    logic [7:0] seq;
    logic       more;
  } hdr_t;

  localparam int HDR_W = $bits(hdr_t);
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
  import radio_tx_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int HEAD_BITS = 84,
  parameter int COV_START = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             startReq,
  input  logic [LEN_W-1:0] payLen,
  input  logic             byteValid,
  output seg_e             seg,
  output logic             byteReady,
  output logic             underrun,
  output strobe_t          strb
);
  localparam int PAY_MAX = 8 * ((1 << LEN_W) - 1);
  localparam int CNT_W   = $clog2((HEAD_BITS > PAY_MAX) ? HEAD_BITS : PAY_MAX) + 1;

  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] lenReg;
  logic [CNT_W-1:0] payLast;
  logic idle, accept, tickAct, lastBit, needByte, starve, headEnd;

  always_comb begin
    idle     = (seg == SEG_IDLE);
    accept   = idle && startReq;
    tickAct  = !idle && bitTick;
    payLast  = (CNT_W'(lenReg) << 3) - CNT_W'(1);
    headEnd  = (seg == SEG_HEAD) && (cnt == CNT_W'(HEAD_BITS - 1));
    lastBit  = headEnd ||
               ((seg == SEG_PAY) && (cnt == payLast)) ||
               ((seg == SEG_CRC) && (cnt == CNT_W'(CRC_W - 1)));
    needByte = (headEnd && (lenReg != '0)) ||
               ((seg == SEG_PAY) && (cnt[2:0] == 3'd7) && (cnt != payLast));
    byteReady = tickAct && needByte;
    starve    = byteReady && !byteValid;
    strb.load     = accept;
    strb.shift    = tickAct;
    strb.byteLoad = byteReady && byteValid;
    strb.crcUpd   = tickAct && (((seg == SEG_HEAD) && (cnt >= CNT_W'(COV_START))) ||
                                (seg == SEG_PAY));
    strb.crcShift = tickAct && (seg == SEG_CRC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seg      <= SEG_IDLE;
      cnt      <= '0;
      lenReg   <= '0;
      underrun <= 1'b0;
    end else if (accept) begin
      seg      <= SEG_HEAD;
      cnt      <= '0;
      lenReg   <= payLen;
      underrun <= 1'b0;
    end else if (tickAct) begin
      if (starve) begin
        seg      <= SEG_IDLE;
        cnt      <= '0;
        underrun <= 1'b1;
      end else if (lastBit) begin
        cnt <= '0;
        unique case (seg)
          SEG_HEAD: seg <= (lenReg != '0) ? SEG_PAY : SEG_CRC;
          SEG_PAY:  seg <= SEG_CRC;
          default:  seg <= SEG_IDLE;
        endcase
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtx_dpath.sv
module rtx_dpath
  import radio_tx_pkg::*;
#(
  parameter int              PRE_BITS  = 24,
  parameter int              SFD_W     = 16,
  parameter logic [SFD_W-1:0] SFD_VALUE = 16'hF3A0,
  parameter int              LEN_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  seg_e             seg,
  input  logic [LEN_W-1:0] payLen,
  input  hdr_t             hdr,
  input  logic [7:0]       byteData,
  output logic             txBit
);
  localparam int HEAD_BITS = PRE_BITS + SFD_W + LEN_W + HDR_W;

  function automatic logic [PRE_BITS-1:0] preambleBits();
    logic [PRE_BITS-1:0] p;
    for (int i = 0; i < PRE_BITS; i++) p[PRE_BITS-1-i] = ~i[0];
    return p;
  endfunction

  localparam logic [PRE_BITS-1:0] PREAMBLE = preambleBits();

  function automatic logic [CRC_W-1:0] crcStep(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  logic [HEAD_BITS-1:0] headSr;
  logic [7:0]           byteSr;
  logic [CRC_W-1:0]     crcReg;

  always_comb begin
    unique case (seg)
      SEG_HEAD: txBit = headSr[HEAD_BITS-1];
      SEG_PAY:  txBit = byteSr[7];
      SEG_CRC:  txBit = crcReg[CRC_W-1];
      default:  txBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headSr <= '0;
      byteSr <= '0;
      crcReg <= CRC_SEED;
    end else if (strb.load) begin
      headSr <= {PREAMBLE, SFD_VALUE, payLen, hdr};
      crcReg <= CRC_SEED;
    end else if (strb.shift) begin
      headSr <= headSr << 1;
      byteSr <= strb.byteLoad ? byteData : (byteSr << 1);
      if (strb.crcUpd)        crcReg <= crcStep(crcReg, txBit);
      else if (strb.crcShift) crcReg <= crcReg << 1;
    end
  end
endmodule

// File: rtl/radio_frame_tx.sv
module radio_frame_tx
  import radio_tx_pkg::*;
#(
  parameter int               PRE_BITS  = 24,
  parameter int               SFD_W     = 16,
  parameter logic [SFD_W-1:0] SFD_VALUE = 16'hF3A0,
  parameter int               LEN_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             startReq,
  input  logic [LEN_W-1:0] payLen,
  input  logic [5:0]       taddr,
  input  logic [5:0]       raddr,
  input  logic [5:0]       saddr,
  input  logic [5:0]       daddr,
  input  logic [2:0]       frameKind,
  input  logic             ackReq,
  input  logic             rsvBit,
  input  logic [7:0]       seqNum,
  input  logic             moreFlag,
  input  logic [7:0]       byteData,
  input  logic             byteValid,
  output logic             byteReady,
  output logic             txBit,
  output logic             txActive,
  output logic             underrun
);
  localparam int HEAD_BITS = PRE_BITS + SFD_W + LEN_W + HDR_W;
  localparam int COV_START = PRE_BITS + SFD_W;

  seg_e    seg;
  strobe_t strb;
  hdr_t    hdr;

  assign hdr = '{ta: taddr, ra: raddr, sa: saddr, da: daddr, kind: frameKind,
                 ack: ackReq, rsv: rsvBit, seq: seqNum, more: moreFlag};
  assign txActive = (seg != SEG_IDLE);

  rtx_ctrl #(.LEN_W(LEN_W), .HEAD_BITS(HEAD_BITS), .COV_START(COV_START)) ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq), .payLen(payLen),
    .byteValid(byteValid), .seg(seg), .byteReady(byteReady), .underrun(underrun),
    .strb(strb)
  );

  rtx_dpath #(.PRE_BITS(PRE_BITS), .SFD_W(SFD_W), .SFD_VALUE(SFD_VALUE), .LEN_W(LEN_W)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .seg(seg), .payLen(payLen), .hdr(hdr),
    .byteData(byteData), .txBit(txBit)
  );
endmodule

// File: rtl/rtx_checker.sv
module rtx_checker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic startReq,
  input logic byteValid,
  input logic byteReady,
  input logic txBit,
  input logic txActive,
  input logic underrun
);
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(startReq));                                 // R2
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && !bitTick) |=> (txActive && $stable(txBit)));             // R3
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (txActive && bitTick));                                 // R6
  AST_STARVE_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (byteReady && !byteValid) |=> (!txActive && underrun && !txBit));     // R8
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!txActive && !startReq) |=> $stable(underrun));                      // R8
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> (!txBit && !byteReady));                                // R1
endmodule

bind radio_frame_tx rtx_checker chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq),
  .byteValid(byteValid), .byteReady(byteReady), .txBit(txBit),
  .txActive(txActive), .underrun(underrun)
);

// File: tb/radio_frame_tx_test.sv
`timescale 1ns/1ps
module radio_frame_tx_test;
  typedef struct packed {
    logic [5:0]  len;
    logic [37:0] hdr;
    logic [7:0]  seed;
    logic        poke;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VEC [NVEC] = '{
    '{len: 6'd0,  hdr: 38'h15_A5C3_0F1E, seed: 8'h11, poke: 1'b0},
    '{len: 6'd1,  hdr: 38'h3F_FFFF_FFFF, seed: 8'hF0, poke: 1'b0},
    '{len: 6'd5,  hdr: 38'h00_0000_0001, seed: 8'h00, poke: 1'b1},
    '{len: 6'd63, hdr: 38'h2B_1234_5678, seed: 8'h5A, poke: 1'b0}
  };

  logic clk = 0, rstN = 0, bitTick = 0, startReq = 0;
  logic [5:0] payLen = 0, taddr = 0, raddr = 0, saddr = 0, daddr = 0;
  logic [2:0] frameKind = 0;
  logic ackReq = 0, rsvBit = 0, moreFlag = 0, byteValid = 0;
  logic [7:0] seqNum = 0, byteData = 0;
  logic byteReady, txBit, txActive, underrun;

  int checks = 0, fails = 0;
  logic expBits [0:639];
  logic gotBits [0:639];
  int nGot, nReady;

  always #10 clk = ~clk;

  radio_frame_tx uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startReq(startReq), .payLen(payLen),
    .taddr(taddr), .raddr(raddr), .saddr(saddr), .daddr(daddr), .frameKind(frameKind),
    .ackReq(ackReq), .rsvBit(rsvBit), .seqNum(seqNum), .moreFlag(moreFlag),
    .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady), .txBit(txBit),
    .txActive(txActive), .underrun(underrun)
  );

  initial begin : tickGen
    int k = 0;
    forever begin
      @(posedge clk); #2;
      k++;
      bitTick = (k % 4 == 0);
    end
  end

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] payByte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  // builds the expected stream; returns its length
  task automatic buildExp(input vec_t v, output int total);
    int idx = 0;
    logic [15:0] c = 16'hFFFF;
    logic [15:0] sfd = 16'hF3A0;
    for (int i = 0; i < 24; i++) expBits[idx++] = ~i[0];
    for (int i = 15; i >= 0; i--) expBits[idx++] = sfd[i];
    for (int i = 5; i >= 0; i--) expBits[idx++] = v.len[i];
    for (int i = 37; i >= 0; i--) expBits[idx++] = v.hdr[i];
    for (int b = 0; b < int'(v.len); b++) begin
      logic [7:0] d = payByte(v.seed, b);
      for (int i = 7; i >= 0; i--) expBits[idx++] = d[i];
    end
    for (int i = 40; i < idx; i++) begin
      logic fb = c[15] ^ expBits[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    for (int i = 15; i >= 0; i--) expBits[idx++] = c[i];
    total = idx;
  endtask

  // stopAt: number of bytes supplied before byteValid drops (-1: never)
  task automatic runFrame(input vec_t v, input int stopAt);
    int byteIdx = 0, guard = 0;
    bit adv;
    @(negedge clk);
    payLen = v.len;
    {taddr, raddr, saddr, daddr, frameKind, ackReq, rsvBit, seqNum, moreFlag} = v.hdr;
    byteData = payByte(v.seed, 0);
    byteValid = (stopAt != 0);
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    check(txActive && txBit, "R2 start shows first preamble bit", {txActive, txBit}, 3);
    nGot = 0; nReady = 0;
    while (txActive && guard < 20000) begin
      adv = 0;
      if (bitTick) begin
        gotBits[nGot] = txBit;
        nGot++;
      end
      if (byteReady && byteValid) begin
        adv = 1;
        nReady++;
      end
      startReq = v.poke && (nGot == 30);
      @(negedge clk);
      guard++;
      if (adv) begin
        byteIdx++;
        byteData = payByte(v.seed, byteIdx);
        if (byteIdx == stopAt) byteValid = 0;
      end
    end
    startReq = 0;
  endtask

  task automatic cmpRange(input int lo, input int hi, input string req);
    int bad = 0, first = -1;
    for (int i = lo; i < hi; i++)
      if (gotBits[i] !== expBits[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    check(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first differing bit index %0d", first);
  endtask

  initial begin : main
    int total;
    repeat (3) @(negedge clk);
    check(!txActive && !txBit && !byteReady && !underrun, "R1 reset state",
          {txActive, txBit, byteReady, underrun}, 0);
    rstN = 1;

    for (int n = 0; n < NVEC; n++) begin
      buildExp(VEC[n], total);
      runFrame(VEC[n], -1);
      check(nGot == total, "R3 frame tick count", nGot, total);
      check(nGot == 100 + 8 * int'(VEC[n].len), "R9 end after last CRC bit", nGot,
            100 + 8 * int'(VEC[n].len));
      cmpRange(0, 40, "R4 preamble and delimiter");
      cmpRange(40, 84, "R5 length and header");
      cmpRange(84, total - 16, "R6 payload bits");
      check(nReady == int'(VEC[n].len), "R6 handshake count", nReady, int'(VEC[n].len));
      cmpRange(total - 16, total, "R7 CRC bits");
      check(!txActive && !txBit, "R9 line idle after frame", {txActive, txBit}, 0);
      if (VEC[n].poke) check(underrun == 0, "R2 mid-frame start ignored", underrun, 0);
    end

    // starve on the first byte
    runFrame(VEC[2], 0);
    check(nGot == 84, "R8 abort at first byte", nGot, 84);
    check(underrun && !txBit && !txActive, "R8 underrun flagged", {underrun, txBit, txActive}, 4);
    repeat (10) @(negedge clk);
    check(underrun == 1, "R8 flag held while idle", underrun, 1);

    // starve after two bytes
    runFrame(VEC[3], 2);
    check(nGot == 100, "R8 abort at third byte", nGot, 100);
    check(nReady == 2, "R8 bytes taken before abort", nReady, 2);
    check(underrun == 1, "R8 underrun after mid-payload abort", underrun, 1);

    // next accepted start clears the flag
    buildExp(VEC[1], total);
    runFrame(VEC[1], -1);
    check(underrun == 0, "R8 flag cleared by new start", underrun, 0);
    cmpRange(0, total, "R7 frame after abort intact");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule